// File: doc/BRIEF.md
# NAND Block Lock Range Controller

This block sits on the device side of a NAND flash core. It watches a byte stream in which every byte is tagged as either a command or an address. From that stream it keeps one protection window, a contiguous range of block addresses that are currently writable. It also keeps a freeze flag that pins that window in place. Each program or erase request carries a block address. The block answers each one with a single-cycle grant or refusal. When a request aims at a protected block, it also raises a short dummy-busy indication, so the host sees a busy period with no array activity.

The window is loaded with the open command (23h), followed by the first block address. Then comes the close command (24h), followed by the last block address. Each address is `ADDR_BYTES` bytes long and arrives least significant byte first. Command 2Ah shuts the window, and command 2Ch freezes the protection state. Command 7Ah, followed by an address, asks for a two-bit protection code for that block.

An active-low write-protect input refuses all operations and clears the freeze. After write-protect is released, a settling interval of `TWW_CYC` cycles must pass before operations are accepted again. Array storage and real program or erase timing are not part of this block.

Top module: `nlr_lock_ctrl`

## Requirements
- R1: After reset the window is empty and the freeze flag is clear. Every block therefore reports code 00 and every request is refused.
- R2: The sequence 23h, start address, 24h, end address makes blocks start..end (inclusive) writable. A request is answered in the cycle after it is presented: `op_grant` for a block inside the window, `op_deny` otherwise, and never both.
- R3: If the end address is below the start address, the window becomes empty and every block is protected.
- R4: A request that the write-protect rules allow, aimed at a protected block, is refused. `dummy_busy` is then high for exactly `BUSY_CYC` cycles, starting in the cycle of the refusal.
- R5: Command 2Ah empties the window when the freeze flag is clear.
- R6: Command 2Ch sets the freeze flag. While the flag is set, commands 23h/24h/2Ah leave the window unchanged, while blocks inside the existing window stay writable.
- R7: While `wp_n` is low, every request is refused without any dummy-busy indication, and the freeze flag is cleared.
- R8: Requests are refused, without dummy busy, for `TWW_CYC` cycles, counted from the first cycle in which `wp_n` is sampled high after being low.
- R9: A window sequence is abandoned when any command other than 24h follows 23h and its address, or when any command interrupts an address. Address bytes outside a sequence are ignored, and the window then keeps its previous value.
- R10: Command 7Ah followed by an address makes `stat_valid` pulse in the cycle after the last address byte. With it comes `stat_code`, where bit 0 = block writable and bit 1 = freeze flag set.
- R11: A request or a query presented in the same cycle as the byte that changes the window or the freeze flag is judged against the state before that change. A query and a request in the same cycle are both answered in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | A byte is present on `bus_byte` this cycle |
| bus_cmd | input | 1 | 1: byte is a command, 0: byte is an address |
| bus_byte | input | 8 | Command or address byte |
| wp_n | input | 1 | Active-low write protect |
| op_req | input | 1 | Program/erase request this cycle |
| op_blk | input | BLK_W | Target block of the request |
| op_grant | output | 1 | Request allowed (one-cycle pulse) |
| op_deny | output | 1 | Request refused (one-cycle pulse) |
| dummy_busy | output | 1 | Short busy shown after a protected-block request |
| stat_valid | output | 1 | Protection code valid |
| stat_code | output | 2 | {freeze, writable} for the queried block |

## Verification
Two functions share a cycle in this block: the judgment of a request, and the update of the window or freeze flag by the last address byte or by a lock command. The bench provokes this by presenting a request on the same cycle as the final end-address byte, and again together with a 2Ah command. Its reference model scores the request before it applies the update, so the answer has to follow the old window. A query that completes in the same cycle as a request is also checked: both answers must come out together, one cycle later.

// File: rtl/nlr_pkg.sv
package nlr_pkg;
  localparam logic [7:0] CMD_RNG_OPEN  = 8'h23;
  localparam logic [7:0] CMD_RNG_CLOSE = 8'h24;
  localparam logic [7:0] CMD_SHUT_ALL  = 8'h2A;
  localparam logic [7:0] CMD_FREEZE    = 8'h2C;
  localparam logic [7:0] CMD_QUERY     = 8'h7A;

  typedef enum logic [2:0] {
    D_IDLE, D_OPEN_ADR, D_WAIT_CLOSE, D_CLOSE_ADR, D_QRY_ADR
  } dec_st_e;

  // block b is writable when the window is enabled and lo <= b <= hi
  function automatic logic blk_open(input logic en, input logic [31:0] lo,
                                    input logic [31:0] hi, input logic [31:0] b);
    return en && (b >= lo) && (b <= hi);
  endfunction

  function automatic logic [1:0] stat_enc(input logic frozen, input logic open);
    return {frozen, open};
  endfunction
endpackage

// File: rtl/nlr_cmd_dec.sv
module nlr_cmd_dec
  import nlr_pkg::*;
#(
  parameter int BLK_W      = 11,
  parameter int ADDR_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_vld,
  input  logic             bus_cmd,
  input  logic [7:0]       bus_byte,
  output logic             commit_ev,
  output logic [BLK_W-1:0] commit_lo,
  output logic [BLK_W-1:0] commit_hi,
  output logic             shut_ev,
  output logic             freeze_ev,
  output logic             query_ev,
  output logic [BLK_W-1:0] ev_blk
);
  localparam int ACC_W  = 8 * ADDR_BYTES;
  localparam int HOLD_W = (ADDR_BYTES > 1) ? 8 * (ADDR_BYTES - 1) : 1;
  localparam int CNT_W  = $clog2(ADDR_BYTES) + 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  dec_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic [ACC_W-1:0] acc_nxt;
  logic [BLK_W-1:0] start_q;
  logic             is_cmd, is_adr, collecting, adr_done;

  assign is_cmd     = bus_vld && bus_cmd;
  assign is_adr     = bus_vld && !bus_cmd;
  assign collecting = (st_q == D_OPEN_ADR) || (st_q == D_CLOSE_ADR) || (st_q == D_QRY_ADR);

  generate
    if (ADDR_BYTES > 1) begin : g_multi
      assign acc_nxt = {bus_byte, hold_q};
    end else begin : g_single
      assign acc_nxt = bus_byte;
    end
  endgenerate

  assign ev_blk    = BLK_W'(acc_nxt);
  assign adr_done  = is_adr && collecting && (cnt_q == LAST_IDX);
  assign commit_ev = adr_done && (st_q == D_CLOSE_ADR);
  assign commit_lo = start_q;
  assign commit_hi = ev_blk;
  assign query_ev  = adr_done && (st_q == D_QRY_ADR);
  assign shut_ev   = is_cmd && (bus_byte == CMD_SHUT_ALL);
  assign freeze_ev = is_cmd && (bus_byte == CMD_FREEZE);

  always_comb begin
    st_d = st_q;
    if (is_cmd) begin
      case (bus_byte)
        CMD_RNG_OPEN:  st_d = D_OPEN_ADR;
        CMD_RNG_CLOSE: st_d = (st_q == D_WAIT_CLOSE) ? D_CLOSE_ADR : D_IDLE;
        CMD_QUERY:     st_d = D_QRY_ADR;
        default:       st_d = D_IDLE;
      endcase
    end else if (adr_done) begin
      st_d = (st_q == D_OPEN_ADR) ? D_WAIT_CLOSE : D_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= D_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
      start_q <= '0;
    end else begin
      st_q <= st_d;
      if (is_cmd || adr_done) cnt_q <= '0;
      else if (is_adr && collecting) cnt_q <= cnt_q + 1'b1;
      if (is_adr && collecting) hold_q <= HOLD_W'(acc_nxt >> 8);
      if (adr_done && (st_q == D_OPEN_ADR)) start_q <= ev_blk;
    end
  end
endmodule

// File: rtl/nlr_prot_state.sv
module nlr_prot_state #(
  parameter int BLK_W   = 11,
  parameter int TWW_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             commit_ev,
  input  logic [BLK_W-1:0] commit_lo,
  input  logic [BLK_W-1:0] commit_hi,
  input  logic             shut_ev,
  input  logic             freeze_ev,
  output logic             rng_en,
  output logic [BLK_W-1:0] rng_lo,
  output logic [BLK_W-1:0] rng_hi,
  output logic             frozen,
  output logic             wp_clear
);
  localparam int GW = $clog2(TWW_CYC + 1);
  localparam logic [GW-1:0] GUARD_LOAD = GW'(TWW_CYC);

  logic [GW-1:0] guard_q;

  assign wp_clear = wp_n && (guard_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rng_en  <= 1'b0;
      rng_lo  <= '0;
      rng_hi  <= '0;
      frozen  <= 1'b0;
      guard_q <= '0;
    end else begin
      if (!wp_n) frozen <= 1'b0;
      else if (freeze_ev) frozen <= 1'b1;

      if (!frozen) begin
        if (commit_ev) begin
          rng_lo <= commit_lo;
          rng_hi <= commit_hi;
          rng_en <= (commit_hi >= commit_lo);
        end else if (shut_ev) begin
          rng_en <= 1'b0;
        end
      end

      if (!wp_n) guard_q <= GUARD_LOAD;
      else if (guard_q != '0) guard_q <= guard_q - 1'b1;
    end
  end
endmodule

// File: rtl/nlr_op_gate.sv
module nlr_op_gate
  import nlr_pkg::*;
#(
  parameter int BLK_W    = 11,
  parameter int BUSY_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_req,
  input  logic [BLK_W-1:0] op_blk,
  input  logic             rng_en,
  input  logic [BLK_W-1:0] rng_lo,
  input  logic [BLK_W-1:0] rng_hi,
  input  logic             wp_clear,
  output logic             lock_hit,
  output logic             op_grant,
  output logic             op_deny,
  output logic             dummy_busy
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYC);

  logic          blk_ok, pass;
  logic [BW-1:0] busy_q;

  assign blk_ok     = blk_open(rng_en, 32'(rng_lo), 32'(rng_hi), 32'(op_blk));
  assign pass       = op_req && wp_clear && blk_ok;
  assign lock_hit   = op_req && wp_clear && !blk_ok;
  assign dummy_busy = (busy_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_grant <= 1'b0;
      op_deny  <= 1'b0;
      busy_q   <= '0;
    end else begin
      op_grant <= pass;
      op_deny  <= op_req && !pass;
      if (lock_hit) busy_q <= BUSY_LOAD;
      else if (busy_q != '0) busy_q <= busy_q - 1'b1;
    end
  end
endmodule

// File: rtl/nlr_lock_ctrl.sv
module nlr_lock_ctrl
  import nlr_pkg::*;
#(
  parameter int BLK_W      = 11,
  parameter int ADDR_BYTES = 2,
  parameter int TWW_CYC    = 5,
  parameter int BUSY_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_vld,
  input  logic             bus_cmd,
  input  logic [7:0]       bus_byte,
  input  logic             wp_n,
  input  logic             op_req,
  input  logic [BLK_W-1:0] op_blk,
  output logic             op_grant,
  output logic             op_deny,
  output logic             dummy_busy,
  output logic             stat_valid,
  output logic [1:0]       stat_code
);
  logic             commit_ev, shut_ev, freeze_ev, query_ev;
  logic [BLK_W-1:0] commit_lo, commit_hi, ev_blk;
  logic             rng_en, frozen, wp_clear, lock_hit;
  logic [BLK_W-1:0] rng_lo, rng_hi;

  nlr_cmd_dec #(.BLK_W(BLK_W), .ADDR_BYTES(ADDR_BYTES)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_cmd(bus_cmd), .bus_byte(bus_byte),
    .commit_ev(commit_ev), .commit_lo(commit_lo), .commit_hi(commit_hi),
    .shut_ev(shut_ev), .freeze_ev(freeze_ev), .query_ev(query_ev), .ev_blk(ev_blk)
  );

  nlr_prot_state #(.BLK_W(BLK_W), .TWW_CYC(TWW_CYC)) u_state (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .commit_ev(commit_ev), .commit_lo(commit_lo), .commit_hi(commit_hi),
    .shut_ev(shut_ev), .freeze_ev(freeze_ev),
    .rng_en(rng_en), .rng_lo(rng_lo), .rng_hi(rng_hi), .frozen(frozen), .wp_clear(wp_clear)
  );

  nlr_op_gate #(.BLK_W(BLK_W), .BUSY_CYC(BUSY_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_blk(op_blk),
    .rng_en(rng_en), .rng_lo(rng_lo), .rng_hi(rng_hi), .wp_clear(wp_clear),
    .lock_hit(lock_hit), .op_grant(op_grant), .op_deny(op_deny), .dummy_busy(dummy_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_code  <= 2'b00;
    end else begin
      stat_valid <= query_ev;
      if (query_ev)
        stat_code <= stat_enc(frozen, blk_open(rng_en, 32'(rng_lo), 32'(rng_hi), 32'(ev_blk)));
    end
  end
endmodule

// File: rtl/nlr_lock_ctrl_chk.sv
module nlr_lock_ctrl_chk #(
  parameter int BLK_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wp_n,
  input logic             op_req,
  input logic             op_grant,
  input logic             op_deny,
  input logic             dummy_busy,
  input logic             lock_hit,
  input logic             frozen,
  input logic             rng_en,
  input logic [BLK_W-1:0] rng_lo,
  input logic [BLK_W-1:0] rng_hi
);
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n) op_req |=> (op_grant ^ op_deny)); // R2
  AST_NO_STRAY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n) !op_req |=> !(op_grant || op_deny)); // R2
  AST_EMPTY_WHEN_REVERSED: assert property (@(posedge clk) disable iff (!rst_n) rng_en |-> (rng_lo <= rng_hi)); // R3
  AST_LOCK_HIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) lock_hit |=> (dummy_busy && op_deny)); // R4
  AST_FROZEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) frozen |=> ($stable(rng_en) && $stable(rng_lo) && $stable(rng_hi))); // R6
  AST_FROZEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (frozen && wp_n) |=> frozen); // R6
  AST_WP_REFUSES: assert property (@(posedge clk) disable iff (!rst_n) (!wp_n && op_req) |=> (op_deny && !op_grant)); // R7
  AST_WP_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (!wp_n && op_req && !dummy_busy) |=> !dummy_busy); // R7
  AST_WP_UNFREEZES: assert property (@(posedge clk) disable iff (!rst_n) !wp_n |=> !frozen); // R7
endmodule

bind nlr_lock_ctrl nlr_lock_ctrl_chk #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .op_req(op_req), .op_grant(op_grant),
  .op_deny(op_deny), .dummy_busy(dummy_busy), .lock_hit(lock_hit), .frozen(frozen),
  .rng_en(rng_en), .rng_lo(rng_lo), .rng_hi(rng_hi)
);

// File: tb/test_nlr_lock_ctrl.sv
module test_nlr_lock_ctrl;
  localparam int BLK_W = 11;
  localparam int ADDR_BYTES = 2;
  localparam int TWW = 5;
  localparam int BUSY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_vld = 1'b0, bus_cmd = 1'b0;
  logic [7:0] bus_byte = 8'h00;
  logic wp_n = 1'b1;
  logic op_req = 1'b0;
  logic [BLK_W-1:0] op_blk = '0;
  logic op_grant, op_deny, dummy_busy, stat_valid;
  logic [1:0] stat_code;

  always #10 clk = ~clk;

  nlr_lock_ctrl #(.BLK_W(BLK_W), .ADDR_BYTES(ADDR_BYTES), .TWW_CYC(TWW), .BUSY_CYC(BUSY)) i_nlr_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_cmd(bus_cmd), .bus_byte(bus_byte),
    .wp_n(wp_n), .op_req(op_req), .op_blk(op_blk), .op_grant(op_grant), .op_deny(op_deny),
    .dummy_busy(dummy_busy), .stat_valid(stat_valid), .stat_code(stat_code)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [1:0] op_q[$];
  string      op_t[$];
  logic [1:0] st_q[$];
  string      st_t[$];

  // reference model
  bit m_en = 0, m_frz = 0;
  int m_lo = 0, m_hi = 0;
  int since = TWW;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_open(int b);
    return m_en && (b >= m_lo) && (b <= m_hi);
  endfunction

  // monitor: pops expectations as answers appear
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (op_grant || op_deny) begin
        if (op_q.size() == 0) chk("R2 unexpected answer", {op_grant, op_deny}, 0);
        else begin
          automatic logic [1:0] e = op_q.pop_front();
          automatic string t = op_t.pop_front();
          chk(t, {op_grant, op_deny}, e);
        end
      end
      if (stat_valid) begin
        if (st_q.size() == 0) chk("R10 unexpected status", stat_code, 9);
        else begin
          automatic logic [1:0] e = st_q.pop_front();
          automatic string t = st_t.pop_front();
          chk(t, stat_code, e);
        end
      end
    end
  end

  // one bus cycle, optional request; expectation taken from the state before the edge
  task automatic step(bit bv, bit bc, logic [7:0] bb, bit rq, int rb, string tag);
    if (rq) begin
      op_q.push_back((wp_n && since >= TWW && m_open(rb)) ? 2'b10 : 2'b01);
      op_t.push_back(tag);
    end
    bus_vld = bv; bus_cmd = bc; bus_byte = bb; op_req = rq; op_blk = BLK_W'(rb);
    @(negedge clk);
    since = wp_n ? since + 1 : 0;
    if (!wp_n) m_frz = 0;
    bus_vld = 0; bus_cmd = 0; op_req = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 0, "");
  endtask

  task automatic op(int b, string tag);
    step(0, 0, 8'h00, 1, b, tag);
  endtask

  task automatic cmd(logic [7:0] c);
    step(1, 1, c, 0, 0, "");
    if (c == 8'h2A && !m_frz) m_en = 0;
    if (c == 8'h2C && wp_n) m_frz = 1;
  endtask

  task automatic adr(int b, bit rq, int rb, string tag);
    for (int i = 0; i < ADDR_BYTES; i++)
      step(1, 0, 8'((b >> (8 * i)) & 255), (i == ADDR_BYTES - 1) && rq, rb, tag);
  endtask

  task automatic unlock(int s, int e, bit rq, int rb, string tag);
    cmd(8'h23); adr(s, 0, 0, ""); cmd(8'h24); adr(e, rq, rb, tag);
    if (!m_frz) begin m_lo = s; m_hi = e; m_en = (e >= s); end
  endtask

  task automatic query(int b, bit rq, int rb, string tag);
    st_q.push_back({m_frz, m_open(b)});
    st_t.push_back(tag);
    cmd(8'h7A); adr(b, rq, rb, tag);
  endtask

  task automatic busy_run(string tag);
    for (int i = 0; i < BUSY; i++) begin chk(tag, dummy_busy, 1); idle(1); end
    chk(tag, dummy_busy, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset grant", op_grant, 0);
    chk("R1 reset deny", op_deny, 0);
    chk("R1 reset busy", dummy_busy, 0);
    chk("R1 reset stat", stat_valid, 0);
    query(0, 0, 0, "R1 status blk0");
    query(2047, 0, 0, "R1 status top blk");
    op(5, "R1 request after reset");
    busy_run("R4 busy length");

    unlock(10, 20, 0, 0, "");
    op(9, "R2 below window");
    op(10, "R2 window start");
    op(20, "R2 window end");
    op(21, "R2 above window");
    query(15, 0, 0, "R10 writable code");
    idle(BUSY);

    unlock(30, 25, 0, 0, "");
    op(27, "R3 reversed inner");
    op(30, "R3 reversed start");
    query(25, 0, 0, "R3 reversed status");
    idle(BUSY);

    unlock(100, 200, 0, 0, "");
    op(150, "R2 wide window");
    cmd(8'h2A);
    op(150, "R5 after shut");
    idle(BUSY);

    unlock(100, 200, 0, 0, "");
    cmd(8'h23); adr(300, 0, 0, ""); cmd(8'h90); cmd(8'h24); adr(400, 0, 0, "");
    step(1, 0, 8'h33, 0, 0, "");
    cmd(8'h23); step(1, 0, 8'h05, 0, 0, ""); cmd(8'h00); cmd(8'h24); adr(900, 0, 0, "");
    op(150, "R9 window kept");
    op(350, "R9 abandoned range");
    op(900, "R9 split address");
    idle(BUSY);

    unlock(500, 600, 1, 550, "R11 request vs commit");
    op(550, "R11 new window");
    query(550, 1, 150, "R11 request beside query");
    step(1, 1, 8'h2A, 1, 550, "R11 request vs shut");
    m_en = 0;
    op(550, "R5 shut applied");
    idle(BUSY);

    unlock(40, 60, 0, 0, "");
    cmd(8'h2C);
    query(50, 0, 0, "R6 frozen writable");
    query(70, 0, 0, "R6 frozen protected");
    cmd(8'h2A);
    op(50, "R6 shut ignored");
    unlock(0, 2047, 0, 0, "");
    op(70, "R6 open ignored");
    idle(BUSY + 1);

    wp_n = 0;
    op(50, "R7 wp refusal");
    chk("R7 no busy", dummy_busy, 0);
    idle(2);
    wp_n = 1;
    for (int i = 0; i <= TWW; i++) op(50, "R8 settle window");
    chk("R8 no busy", dummy_busy, 0);
    query(50, 0, 0, "R7 freeze cleared");
    cmd(8'h2A);
    op(50, "R7 shut after unfreeze");
    idle(BUSY + 2);

    chk("R2 answers pending", op_q.size(), 0);
    chk("R10 status pending", st_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule